// File: doc/BRIEF.md
# Three-Wire Register Access Slave

This block is a slave on a three-wire serial control bus. The bus has a serial clock, an active-low select line and one shared data line, which the block sees as a separate input, output and output enable. The host opens a frame by pulling the select line low. It then shifts a 9-bit control word, most significant bit first. The control word carries a 4-bit chip identity, a direction flag and a 4-bit register index. A write frame goes on with 16 data bits, which land in one of 16 configuration registers once the host closes the frame. A read frame turns the line around for half a clock and then shifts the selected register out.

All bus pins are brought into the system clock domain through synchronizers and then edge-detected. The block never clocks on the serial clock, so the serial clock may keep running between frames. The configuration registers are exported as one flat vector, so the rest of the chip can use them directly.

Top module: `tw_reg_slave`

## Requirements
- R1: After reset, every configuration register holds zero and the output enable is low.
- R2: A frame's first bit is taken on the first rising serial clock edge at which select is low. Control bits arrive in this order: identity bit 3, bit 2, bit 1, then the direction flag, then identity bit 0, then register index bits 3 down to 0.
- R3: The frame is addressed to the block only when the received identity equals 0110b. The 4-bit index selects one of registers 0 to 15.
- R4: With the direction flag at 0 (write), the 16 data bits that follow are taken MSB first. The register is updated at the first falling serial clock edge that is seen with select high, once all 25 bits have arrived.
- R5: After the 25th bit, the target register keeps its old value for as long as select stays low.
- R6: A write frame closed before its 25th bit changes no register.
- R7: A frame with a different identity changes no register and never raises the output enable.
- R8: With the direction flag at 1 (read), the output enable rises at the falling edge after the last control bit. The register's bit 15 is valid before the next rising edge, and each later rising edge advances one bit toward bit 0.
- R9: The output enable drops within four system clocks after select goes high.
- R10: A read frame leaves every register unchanged.
- R11: Serial clock edges seen while select is high neither start a frame nor change any register.
- R12: Extra serial clock edges after bit 25 of a write frame are ignored; the first 16 data bits are the ones committed.
- R13: When select rises in the same synchronized sample as a falling serial clock edge after a full write, that edge commits the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| sen_n | input | 1 | Active-low frame select |
| sdio_i | input | 1 | Serial data line, input side |
| sdio_o | output | 1 | Serial data line, driven value |
| sdio_oe | output | 1 | Output enable for the data line |
| regs_o | output | 256 | All 16 registers, register k in bits 16k+15 to 16k |

## Verification
Two events can meet in one sampled cycle: the end of a frame, when select rises, and the commit edge, a falling serial clock with select high. The bench provokes this by raising select at the very system clock edge where it lowers the serial clock after the 25th bit. That edge must commit the write, and the later trailing clock must not commit it a second time. It also holds select low after a full write to show that the commit waits for the release. It then checks that the register appears only after the release.

// File: rtl/tw_pkg.sv
package tw_pkg;

   // Edge event seen on the synchronized serial clock in one system cycle.
   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_RISE = 2'd1,
      EV_FALL = 2'd2
   } sclk_ev_e;

   localparam int DEF_DATA_W      = 16;
   localparam int DEF_ADDR_W      = 4;
   localparam int DEF_ID_W        = 4;
   localparam int DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tw_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("tw_sync: W must be positive");
   end

   logic [STAGES-1:0][W-1:0] st_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q[s] <= RST_VAL;
            else        st_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q[s] <= RST_VAL;
            else        st_q[s] <= st_q[s-1];
         end
      end
   end

   assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/tw_frame_dec.sv
module tw_frame_dec
   import tw_pkg::*;
#(
   parameter int              DATA_W  = 16,
   parameter int              ADDR_W  = 4,
   parameter int              ID_W    = 4,
   parameter logic [ID_W-1:0] CHIP_ID = 4'b0110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              sen_n_i,
   input  logic              sdio_i,
   output sclk_ev_e          ev_o,
   output logic              sen_hi_o,
   output logic              rd_load_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              rd_hit_o,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              pend_o
);

   localparam int CTRL_W  = ID_W + 1 + ADDR_W;
   localparam int FRAME_W = CTRL_W + DATA_W;
   localparam int CNT_W   = $clog2(FRAME_W + 1);
   localparam int RW_IDX  = ADDR_W + 1;

   if (ID_W < 2) begin : g_bad_id
      $error("tw_frame_dec: ID_W must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("tw_frame_dec: DATA_W must be at least 2");
   end

   logic              sclk_d;
   sclk_ev_e          ev;
   logic [CNT_W-1:0]  cnt_q;
   logic [CTRL_W-1:0] ctrl_q, ctrl_nx;
   logic [DATA_W-1:0] data_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ID_W-1:0]   id_nx;
   logic              hit_q, rd_q, pend_q;
   logic              hit_nx, rd_nx, ctl_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_i;
   end

   always_comb begin
      ev = EV_NONE;
      if (sclk_i && !sclk_d)      ev = EV_RISE;
      else if (!sclk_i && sclk_d) ev = EV_FALL;
   end

   // Control word as it stands once the current bit is shifted in.
   assign ctrl_nx  = {ctrl_q[CTRL_W-2:0], sdio_i};
   assign id_nx    = {ctrl_nx[CTRL_W-1 -: ID_W-1], ctrl_nx[ADDR_W]};
   assign hit_nx   = (id_nx == CHIP_ID);
   assign rd_nx    = ctrl_nx[RW_IDX];
   assign ctl_edge = (ev == EV_RISE) && !sen_n_i && (cnt_q == CNT_W'(CTRL_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         ctrl_q <= '0;
         data_q <= '0;
         addr_q <= '0;
         hit_q  <= 1'b0;
         rd_q   <= 1'b0;
         pend_q <= 1'b0;
      end else if (ev == EV_RISE) begin
         if (sen_n_i) begin
            cnt_q <= '0;
            hit_q <= 1'b0;
            rd_q  <= 1'b0;
         end else begin
            if (cnt_q == '0) pend_q <= 1'b0;
            if (cnt_q < CNT_W'(FRAME_W)) begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q < CNT_W'(CTRL_W)) ctrl_q <= ctrl_nx;
               else                        data_q <= {data_q[DATA_W-2:0], sdio_i};
               if (cnt_q == CNT_W'(CTRL_W - 1)) begin
                  hit_q  <= hit_nx;
                  rd_q   <= rd_nx;
                  addr_q <= ctrl_nx[ADDR_W-1:0];
               end
               if (cnt_q == CNT_W'(FRAME_W - 1) && hit_q && !rd_q) pend_q <= 1'b1;
            end
         end
      end else if (ev == EV_FALL && sen_n_i && pend_q) begin
         pend_q <= 1'b0;
      end
   end

   assign ev_o      = ev;
   assign sen_hi_o  = sen_n_i;
   assign rd_load_o = ctl_edge && hit_nx && rd_nx;
   assign rd_addr_o = ctrl_nx[ADDR_W-1:0];
   assign rd_hit_o  = hit_q && rd_q;
   assign wr_en_o   = (ev == EV_FALL) && sen_n_i && pend_q;
   assign wr_addr_o = addr_q;
   assign wr_data_o = data_q;
   assign pend_o    = pend_q;

   // R7: a commit can only be armed by a matching write control word.
   p_pend_needs_write_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> (hit_q && !rd_q));

   // R6: arming happens on a rising edge sampled with select low.
   p_pend_on_low_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(ev == EV_RISE && !sen_n_i));

endmodule

// File: rtl/tw_regs.sv
module tw_regs #(
   parameter int              DATA_W   = 16,
   parameter int              ADDR_W   = 4,
   parameter logic [DATA_W-1:0] RST_WORD = '0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en_i,
   input  logic [ADDR_W-1:0]               wr_addr_i,
   input  logic [DATA_W-1:0]               wr_data_i,
   input  logic [ADDR_W-1:0]               rd_addr_i,
   output logic [DATA_W-1:0]               rd_word_o,
   output logic [(2**ADDR_W)*DATA_W-1:0]   regs_o
);

   localparam int NREG = 2 ** ADDR_W;

   logic [NREG-1:0][DATA_W-1:0] mem_q;

   for (genvar k = 0; k < NREG; k++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem_q[k] <= RST_WORD;
         else if (wr_en_i && wr_addr_i == ADDR_W'(k))
            mem_q[k] <= wr_data_i;
      end
      assign regs_o[k*DATA_W +: DATA_W] = mem_q[k];
   end

   assign rd_word_o = mem_q[rd_addr_i];

   // R4 / R10: storage only moves in the cycle after a commit strobe.
   p_change_only_on_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mem_q) |-> $past(wr_en_i));

endmodule

// File: rtl/tw_readout.sv
module tw_readout
   import tw_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sclk_ev_e          ev_i,
   input  logic              sen_hi_i,
   input  logic              rd_hit_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] load_word_i,
   output logic              sdio_o,
   output logic              sdio_oe_o
);

   logic [DATA_W-1:0] sh_q;
   logic              arm_q, oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         arm_q <= 1'b0;
         oe_q  <= 1'b0;
      end else if (sen_hi_i) begin
         arm_q <= 1'b0;
         oe_q  <= 1'b0;
      end else if (load_i) begin
         sh_q  <= load_word_i;
         arm_q <= 1'b1;
      end else if (ev_i == EV_FALL && arm_q) begin
         oe_q  <= 1'b1;
         arm_q <= 1'b0;
      end else if (ev_i == EV_RISE && oe_q) begin
         sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
      end
   end

   assign sdio_o    = oe_q & sh_q[DATA_W-1];
   assign sdio_oe_o = oe_q;

   // R7: the line is only driven inside a matching read frame.
   p_oe_gated_by_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      oe_q |-> rd_hit_i);

   // R9: select high always releases the line.
   p_oe_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sen_hi_i |=> !oe_q);

   // R8: the drive starts on a falling edge, after the turnaround half cycle.
   p_oe_starts_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> $past(ev_i == EV_FALL));

endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave
   import tw_pkg::*;
#(
   parameter int              DATA_W      = DEF_DATA_W,
   parameter int              ADDR_W      = DEF_ADDR_W,
   parameter int              ID_W        = DEF_ID_W,
   parameter logic [ID_W-1:0] CHIP_ID     = 4'b0110,
   parameter int              SYNC_STAGES = DEF_SYNC_STAGES,
   parameter logic [DATA_W-1:0] RST_WORD  = '0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sclk,
   input  logic                          sen_n,
   input  logic                          sdio_i,
   output logic                          sdio_o,
   output logic                          sdio_oe,
   output logic [(2**ADDR_W)*DATA_W-1:0] regs_o
);

   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
      $error("tw_reg_slave: ADDR_W out of range");
   end

   logic              sclk_s, sen_n_s, sdio_s;
   sclk_ev_e          ev;
   logic              sen_hi, rd_load, rd_hit, wr_en, pend;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic [DATA_W-1:0] wr_data, rd_word;

   tw_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({sclk, sen_n, sdio_i}),
      .q_o   ({sclk_s, sen_n_s, sdio_s})
   );

   tw_frame_dec #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .ID_W    (ID_W),
      .CHIP_ID (CHIP_ID)
   ) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_i    (sclk_s),
      .sen_n_i   (sen_n_s),
      .sdio_i    (sdio_s),
      .ev_o      (ev),
      .sen_hi_o  (sen_hi),
      .rd_load_o (rd_load),
      .rd_addr_o (rd_addr),
      .rd_hit_o  (rd_hit),
      .wr_en_o   (wr_en),
      .wr_addr_o (wr_addr),
      .wr_data_o (wr_data),
      .pend_o    (pend)
   );

   tw_regs #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .RST_WORD (RST_WORD)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .rd_addr_i (rd_addr),
      .rd_word_o (rd_word),
      .regs_o    (regs_o)
   );

   tw_readout #(
      .DATA_W (DATA_W)
   ) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev_i        (ev),
      .sen_hi_i    (sen_hi),
      .rd_hit_i    (rd_hit),
      .load_i      (rd_load),
      .load_word_i (rd_word),
      .sdio_o      (sdio_o),
      .sdio_oe_o   (sdio_oe)
   );

   // R10: a driven read and an armed write commit never coexist.
   p_oe_excl_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sdio_oe |-> !pend);

endmodule

// File: tb/sim_tw_reg_slave.sv
module sim_tw_reg_slave;

   localparam int HP = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sclk = 1'b0;
   logic         sen_n = 1'b1;
   logic         sdio_i = 1'b0;
   logic         sdio_o, sdio_oe;
   logic [255:0] regs_o;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   logic [15:0] model [16];
   logic [15:0] exp_q [$];
   logic [15:0] act_q [$];

   always #4 clk = ~clk;

   tw_reg_slave u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk    (sclk),
      .sen_n   (sen_n),
      .sdio_i  (sdio_i),
      .sdio_o  (sdio_o),
      .sdio_oe (sdio_oe),
      .regs_o  (regs_o)
   );

   task automatic note(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sclk_cycle(input logic b);
      sdio_i = b;
      wait_clk(HP);
      sclk = 1'b1;
      wait_clk(HP);
      sclk = 1'b0;
   endtask

   task automatic chk_regs(input string req);
      bit ok = 1'b1;
      for (int k = 0; k < 16; k++)
         if (regs_o[k*16 +: 16] !== model[k]) begin
            ok = 1'b0;
            note(1'b0, req, {16'd0, regs_o[k*16 +: 16]}, {16'd0, model[k]});
         end
      if (ok) note(1'b1, req, 32'd0, 32'd0);
   endtask

   // Write frame: nbits edges with select low, then one trailing clock with select high.
   task automatic wr_frame(input logic [3:0] id, input logic [3:0] a, input logic [15:0] d,
                           input int nbits, input bit coincide, input bit hold_chk);
      logic [24:0] v;
      v = {id[3:1], 1'b0, id[0], a, d};
      sen_n = 1'b0;
      for (int i = 0; i < nbits; i++) begin
         if (coincide && i == nbits - 1) begin
            sdio_i = v[0];
            wait_clk(HP);
            sclk = 1'b1;
            wait_clk(HP);
            sclk = 1'b0;
            sen_n = 1'b1;
         end else begin
            sclk_cycle(i < 25 ? v[24-i] : 1'b1);
         end
      end
      if (hold_chk) begin
         wait_clk(HP);
         chk_regs("R5 hold while select low");
      end
      sen_n = 1'b1;
      wait_clk(HP);
      sclk = 1'b1;
      wait_clk(HP);
      sclk = 1'b0;
      wait_clk(6);
   endtask

   task automatic rd_frame(input logic [3:0] id, input logic [3:0] a, input bit expect_hit);
      logic [8:0]  c;
      logic [15:0] got;
      bit          oe_bad;
      c = {id[3:1], 1'b1, id[0], a};
      got = '0;
      oe_bad = 1'b0;
      sen_n = 1'b0;
      for (int i = 0; i < 9; i++) sclk_cycle(c[8-i]);
      if (expect_hit) exp_q.push_back(model[a]);
      for (int k = 0; k < 16; k++) begin
         sdio_i = k[0];
         wait_clk(HP);
         got[15-k] = sdio_o;
         if (sdio_oe !== expect_hit) oe_bad = 1'b1;
         sclk = 1'b1;
         wait_clk(HP);
         sclk = 1'b0;
      end
      sen_n = 1'b1;
      wait_clk(5);
      note(sdio_oe === 1'b0, "R9 oe release", {31'd0, sdio_oe}, 32'd0);
      wait_clk(HP - 5);
      sclk = 1'b1;
      wait_clk(HP);
      sclk = 1'b0;
      wait_clk(4);
      note(!oe_bad, expect_hit ? "R8 oe during read" : "R7 no drive on mismatch",
           {31'd0, oe_bad}, 32'd0);
      if (expect_hit) act_q.push_back(got);
      wait_clk(2);
   endtask

   // Scoreboard monitor: compares each shifted-out word with the queued expectation.
   always @(negedge clk) begin
      if (act_q.size() > 0 && exp_q.size() > 0) begin
         logic [15:0] a_w, e_w;
         a_w = act_q.pop_front();
         e_w = exp_q.pop_front();
         note(a_w === e_w, "R8 read data", {16'd0, a_w}, {16'd0, e_w});
      end
   end

   initial begin
      for (int k = 0; k < 16; k++) model[k] = 16'h0000;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);

      // R1 reset state
      chk_regs("R1 reset regs");
      note(sdio_oe === 1'b0, "R1 reset oe", {31'd0, sdio_oe}, 32'd0);

      // R2 R3 R4 R5: basic write with hold check
      wr_frame(4'b0110, 4'd3, 16'hA5C3, 25, 1'b0, 1'b1);
      model[3] = 16'hA5C3;
      chk_regs("R4 write commit");

      // R3 index boundaries
      wr_frame(4'b0110, 4'd0, 16'h1234, 25, 1'b0, 1'b0);
      wr_frame(4'b0110, 4'd15, 16'hFFFF, 25, 1'b0, 1'b0);
      model[0] = 16'h1234;
      model[15] = 16'hFFFF;
      chk_regs("R3 index 0 and 15");

      // R8 R10 reads
      rd_frame(4'b0110, 4'd3, 1'b1);
      rd_frame(4'b0110, 4'd15, 1'b1);
      rd_frame(4'b0110, 4'd0, 1'b1);
      chk_regs("R10 read leaves regs");

      // R7 R2 identity mismatches, one differing in the bit after the direction flag
      wr_frame(4'b0111, 4'd3, 16'h0BAD, 25, 1'b0, 1'b0);
      wr_frame(4'b1110, 4'd4, 16'h0BAD, 25, 1'b0, 1'b0);
      chk_regs("R7 mismatch write ignored");
      rd_frame(4'b0100, 4'd3, 1'b0);

      // R6 partial writes
      wr_frame(4'b0110, 4'd6, 16'hDEAD, 20, 1'b0, 1'b0);
      wr_frame(4'b0110, 4'd6, 16'hDEAD, 24, 1'b0, 1'b0);
      chk_regs("R6 partial write dropped");

      // R12 extra clocks
      wr_frame(4'b0110, 4'd5, 16'h0F0F, 30, 1'b0, 1'b0);
      model[5] = 16'h0F0F;
      chk_regs("R12 extra clocks ignored");

      // R11 clocks with select high
      sen_n = 1'b1;
      for (int i = 0; i < 6; i++) sclk_cycle(i[0]);
      wait_clk(4);
      chk_regs("R11 idle clocks");
      wr_frame(4'b0110, 4'd7, 16'h5A5A, 25, 1'b0, 1'b0);
      model[7] = 16'h5A5A;
      chk_regs("R11 write after idle clocks");

      // R13 select rise coinciding with the falling edge
      wr_frame(4'b0110, 4'd9, 16'h8001, 25, 1'b1, 1'b0);
      model[9] = 16'h8001;
      chk_regs("R13 coincident commit");

      rd_frame(4'b0110, 4'd9, 1'b1);
      rd_frame(4'b0110, 4'd5, 1'b1);
      rd_frame(4'b0110, 4'd6, 1'b1);
      wait_clk(4);
      note(exp_q.size() == 0 && act_q.size() == 0, "R8 scoreboard drained",
           exp_q.size(), 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

endmodule